// File: doc/BRIEF.md
# Object Field Cache

This block is a small associative cache for words that live inside heap objects. It is addressed by an object reference together with a field index, not by a byte address. Each cache line belongs to one object and holds a fixed number of that object's fields. Every field has its own valid bit, so a line can be resident while only some of its fields hold data.

A requester presents a reference and a field index on the lookup port. One cycle later the block answers with hit or miss and, on a hit, the field word. On a miss the requester fetches the word itself and installs it through the write port as a fill. Field stores from the requester go through the same port. A store updates the cached copy only when the object is already resident. A single-cycle invalidate input empties the whole cache.

Inside, the tags of all lines are compared with the reference in parallel. At the same time the field index picks one valid bit from each line. An encoder combines the two results into a hit flag and a line number. The data storage is addressed by that line number joined with the field index.

Top module: `ofc_object_cache`

## Requirements
- R1: Exactly one cycle after a cycle with `lk_req_i` high, `lk_valid_o` is high and carries the answer. After a cycle with `lk_req_i` low, `lk_valid_o` and `lk_hit_o` are low.
- R2: A lookup hits only when some line holds the same reference as its tag and that line's valid bit for the requested field is set. On a hit `lk_data_o` is the word last written to that field. On a miss `lk_data_o` is zero.
- R3: A reference occupies at most one line. A fill or store for a reference that is already resident always goes to the line that holds it.
- R4: Valid bits are kept per field. A lookup of a field that was never written misses, even while other fields of the same object hit.
- R5: A fill whose reference matches no line allocates the line named by a round-robin pointer. The pointer starts at line 0 after reset and steps by one, modulo the number of lines, on each allocation. The new line takes the reference as its tag and has only the filled field valid.
- R6: A fill whose reference is resident writes the word and sets that field's valid bit. It leaves the other fields of the line and the round-robin pointer unchanged.
- R7: A store (`wr_store_i` = 1) whose reference is resident overwrites the field word and marks that field valid.
- R8: A store whose reference is not resident changes nothing: it allocates no line, evicts nothing and does not move the pointer.
- R9: `flush_i` clears every valid bit in one cycle. A write presented in the same cycle is dropped.
- R10: A lookup presented in the same cycle as a write or flush is answered from the contents as they were before that cycle's update.
- R11: After reset every line is invalid, the pointer is at line 0 and `lk_valid_o`, `lk_hit_o` and `lk_data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all lines |
| lk_req_i | input | 1 | Lookup request |
| lk_ref_i | input | REF_W | Object reference to look up |
| lk_fidx_i | input | FIDX_W | Field index to look up |
| wr_en_i | input | 1 | Write request (fill or store) |
| wr_store_i | input | 1 | 0 = fill after a miss, 1 = field store |
| wr_ref_i | input | REF_W | Object reference of the write |
| wr_fidx_i | input | FIDX_W | Field index of the write |
| wr_data_i | input | DATA_W | Field word to write |
| lk_valid_o | output | 1 | Lookup answer present |
| lk_hit_o | output | 1 | Lookup hit |
| lk_data_o | output | DATA_W | Field word on hit, zero on miss |

## Verification
The embedded assertions watch the timing of the answer, a lookup hit that was never requested, duplicate ownership of a reference, a complete flush, and pointer movement, every cycle. The pointer checks cover a step on allocation and no movement on a fill hit or a store miss. The bench scenarios are the only place that shows which line is evicted, that partly valid lines give per-field hit and miss, and that store data is written through correctly. They also show the before-update view of same-cycle lookups and that a write is dropped under flush.

// File: rtl/ofc_pkg.sv
package ofc_pkg;

  // Write port operation selected by wr_store_i
  typedef enum logic {
    OFC_WR_FILL  = 1'b0,
    OFC_WR_STORE = 1'b1
  } ofc_wr_kind_e;

  // Round-robin successor of a line number among 'ways' lines
  function automatic int unsigned rr_advance(int unsigned cur, int unsigned ways);
    return (cur + 1 >= ways) ? 0 : cur + 1;
  endfunction

  // Number of bits needed to index 'n' items, never less than one
  function automatic int unsigned idx_bits(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/ofc_tag_array.sv
module ofc_tag_array
  import ofc_pkg::*;
#(
  parameter int unsigned WAYS   = 2,
  parameter int unsigned FIELDS = 4,
  parameter int unsigned REF_W  = 32,
  localparam int unsigned LINE_W = idx_bits(WAYS),
  localparam int unsigned FIDX_W = idx_bits(FIELDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [REF_W-1:0]  lk_ref_i,
  input  logic [FIDX_W-1:0] lk_fidx_i,
  input  logic [REF_W-1:0]  wr_ref_i,
  input  logic              upd_en_i,
  input  logic              upd_alloc_i,
  input  logic [LINE_W-1:0] upd_line_i,
  input  logic [FIDX_W-1:0] upd_fidx_i,
  output logic [WAYS-1:0]   lk_match_o,
  output logic [WAYS-1:0]   lk_fsel_o,
  output logic [WAYS-1:0]   wr_match_o,
  output logic [WAYS-1:0]   live_o,
  output logic [LINE_W-1:0] rr_o
);

  logic [REF_W-1:0]  tag_q   [WAYS];
  logic [FIELDS-1:0] valid_q [WAYS];
  logic [LINE_W-1:0] rr_q;

  // Parallel compare of every line against both ports
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign live_o[w]     = |valid_q[w];
    assign lk_match_o[w] = live_o[w] && (tag_q[w] == lk_ref_i);
    assign lk_fsel_o[w]  = valid_q[w][lk_fidx_i];
    assign wr_match_o[w] = live_o[w] && (tag_q[w] == wr_ref_i);
  end

  assign rr_o = rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) begin
        tag_q[w]   <= '0;
        valid_q[w] <= '0;
      end
      rr_q <= '0;
    end else if (flush_i) begin
      for (int w = 0; w < WAYS; w++) valid_q[w] <= '0;
    end else if (upd_en_i) begin
      if (upd_alloc_i) begin
        tag_q[upd_line_i]   <= wr_ref_i;
        valid_q[upd_line_i] <= FIELDS'(1) << upd_fidx_i;
        rr_q                <= LINE_W'(rr_advance(int'(rr_q), WAYS));
      end else begin
        valid_q[upd_line_i][upd_fidx_i] <= 1'b1;
      end
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (live_o == '0)); // R9

  AST_ONE_OWNER_LK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match_o)); // R3

  AST_ONE_OWNER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_match_o)); // R3

  AST_ALLOC_STEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en_i && upd_alloc_i && !flush_i) |=>
      (int'(rr_q) == rr_advance(int'($past(rr_q)), WAYS))); // R5

endmodule

// File: rtl/ofc_hit_encoder.sv
module ofc_hit_encoder
  import ofc_pkg::*;
#(
  parameter int unsigned WAYS = 2,
  localparam int unsigned LINE_W = idx_bits(WAYS)
) (
  input  logic [WAYS-1:0]   match_i,
  input  logic [WAYS-1:0]   sel_i,
  output logic              hit_o,
  output logic [LINE_W-1:0] line_o
);

  // OR-encoder: at most one line can qualify, so OR of indices is exact
  always_comb begin
    hit_o  = 1'b0;
    line_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match_i[w] && sel_i[w]) begin
        hit_o  = 1'b1;
        line_o = line_o | LINE_W'(w);
      end
    end
  end

endmodule

// File: rtl/ofc_data_ram.sv
module ofc_data_ram #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // Registered read returns the word as it was before this cycle's write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/ofc_object_cache.sv
module ofc_object_cache
  import ofc_pkg::*;
#(
  parameter int unsigned WAYS   = 2,
  parameter int unsigned FIELDS = 4,
  parameter int unsigned REF_W  = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LINE_W = idx_bits(WAYS),
  localparam int unsigned FIDX_W = idx_bits(FIELDS),
  localparam int unsigned ADDR_W = LINE_W + FIDX_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              lk_req_i,
  input  logic [REF_W-1:0]  lk_ref_i,
  input  logic [FIDX_W-1:0] lk_fidx_i,
  input  logic              wr_en_i,
  input  logic              wr_store_i,
  input  logic [REF_W-1:0]  wr_ref_i,
  input  logic [FIDX_W-1:0] wr_fidx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              lk_valid_o,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_data_o
);

  // Data address: line number joined with field index
  function automatic logic [ADDR_W-1:0] field_addr(logic [LINE_W-1:0] line,
                                                   logic [FIDX_W-1:0] fidx);
    return {line, fidx};
  endfunction

  logic [WAYS-1:0]   lk_match, lk_fsel, wr_match, live;
  logic [LINE_W-1:0] rr;
  logic              lk_hit_c, wr_hit_c;
  logic [LINE_W-1:0] lk_line_c, wr_line_c, upd_line;
  logic              is_store, write_go, alloc_go;
  logic              lk_valid_q, lk_hit_q;
  logic [DATA_W-1:0] ram_q;

  ofc_tag_array #(.WAYS(WAYS), .FIELDS(FIELDS), .REF_W(REF_W)) u_tags (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .lk_ref_i    (lk_ref_i),
    .lk_fidx_i   (lk_fidx_i),
    .wr_ref_i    (wr_ref_i),
    .upd_en_i    (write_go),
    .upd_alloc_i (alloc_go),
    .upd_line_i  (upd_line),
    .upd_fidx_i  (wr_fidx_i),
    .lk_match_o  (lk_match),
    .lk_fsel_o   (lk_fsel),
    .wr_match_o  (wr_match),
    .live_o      (live),
    .rr_o        (rr)
  );

  // Lookup side: tag match qualified by the selected field valid bit
  ofc_hit_encoder #(.WAYS(WAYS)) u_lk_enc (
    .match_i (lk_match),
    .sel_i   (lk_fsel),
    .hit_o   (lk_hit_c),
    .line_o  (lk_line_c)
  );

  // Write side: tag match alone decides residency
  ofc_hit_encoder #(.WAYS(WAYS)) u_wr_enc (
    .match_i (wr_match),
    .sel_i   ({WAYS{1'b1}}),
    .hit_o   (wr_hit_c),
    .line_o  (wr_line_c)
  );

  assign is_store = (ofc_wr_kind_e'(wr_store_i) == OFC_WR_STORE);
  assign write_go = wr_en_i && !flush_i && (!is_store || wr_hit_c);
  assign alloc_go = write_go && !wr_hit_c;
  assign upd_line = wr_hit_c ? wr_line_c : rr;

  ofc_data_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (write_go),
    .waddr_i (field_addr(upd_line, wr_fidx_i)),
    .wdata_i (wr_data_i),
    .raddr_i (field_addr(lk_line_c, lk_fidx_i)),
    .rdata_o (ram_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_valid_q <= 1'b0;
      lk_hit_q   <= 1'b0;
    end else begin
      lk_valid_q <= lk_req_i;
      lk_hit_q   <= lk_req_i && lk_hit_c;
    end
  end

  assign lk_valid_o = lk_valid_q;
  assign lk_hit_o   = lk_hit_q;
  assign lk_data_o  = lk_hit_q ? ram_q : '0;

  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req_i |=> lk_valid_o); // R1

  AST_NO_STRAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid_o |-> (!lk_hit_o && lk_data_o == '0)); // R1

  AST_FILL_HIT_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_store_i && wr_hit_c) |=> $stable(rr)); // R6

  AST_STORE_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_store_i && !wr_hit_c && !flush_i) |=>
      ($stable(rr) && $stable(live))); // R8

endmodule

// File: tb/ofc_object_cache_tb_top.sv
`timescale 1ns/1ps
module ofc_object_cache_tb_top;

  localparam int WAYS = 2;
  localparam int FIELDS = 4;
  localparam int REF_W = 32;
  localparam int DATA_W = 32;
  localparam int FIDX_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush_i = 0, lk_req_i = 0, wr_en_i = 0, wr_store_i = 0;
  logic [REF_W-1:0] lk_ref_i = '0, wr_ref_i = '0;
  logic [FIDX_W-1:0] lk_fidx_i = '0, wr_fidx_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic lk_valid_o, lk_hit_o;
  logic [DATA_W-1:0] lk_data_o;

  always #2 clk = ~clk; // 250 MHz

  ofc_object_cache #(.WAYS(WAYS), .FIELDS(FIELDS), .REF_W(REF_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .lk_req_i(lk_req_i), .lk_ref_i(lk_ref_i), .lk_fidx_i(lk_fidx_i),
    .wr_en_i(wr_en_i), .wr_store_i(wr_store_i), .wr_ref_i(wr_ref_i),
    .wr_fidx_i(wr_fidx_i), .wr_data_i(wr_data_i),
    .lk_valid_o(lk_valid_o), .lk_hit_o(lk_hit_o), .lk_data_o(lk_data_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    bit          vld;
    bit          hit;
    logic [31:0] data;
    string       rq;
  } exp_t;
  exp_t sb_q[$];

  // Reference model built from the requirements
  logic [REF_W-1:0]  m_tag [WAYS];
  bit   [FIELDS-1:0] m_val [WAYS];
  logic [DATA_W-1:0] m_dat [WAYS][FIELDS];
  int m_rr = 0;

  function automatic int m_find(logic [REF_W-1:0] r);
    for (int w = 0; w < WAYS; w++)
      if (m_val[w] != 0 && m_tag[w] == r) return w;
    return -1;
  endfunction

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // One bus cycle: model answers the lookup before the update (R10)
  task automatic cyc(bit lk, logic [31:0] lref, int lf,
                     bit we, bit st, logic [31:0] wref, int wf,
                     logic [31:0] wd, bit fl, string rq);
    exp_t e;
    int l;
    @(negedge clk);
    e.vld = lk; e.hit = 0; e.data = '0; e.rq = rq;
    if (lk) begin
      l = m_find(lref);
      if (l >= 0 && m_val[l][lf]) begin e.hit = 1; e.data = m_dat[l][lf]; end
    end
    sb_q.push_back(e);
    if (fl) begin
      for (int w = 0; w < WAYS; w++) m_val[w] = '0;
    end else if (we) begin
      l = m_find(wref);
      if (l >= 0) begin
        m_val[l][wf] = 1'b1; m_dat[l][wf] = wd;
      end else if (!st) begin
        m_tag[m_rr] = wref; m_val[m_rr] = '0; m_val[m_rr][wf] = 1'b1;
        m_dat[m_rr][wf] = wd; m_rr = (m_rr + 1) % WAYS;
      end
    end
    lk_req_i = lk; lk_ref_i = lref; lk_fidx_i = FIDX_W'(lf);
    wr_en_i = we; wr_store_i = st; wr_ref_i = wref; wr_fidx_i = FIDX_W'(wf);
    wr_data_i = wd; flush_i = fl;
  endtask

  task automatic look(logic [31:0] r, int f, string rq);
    cyc(1, r, f, 0, 0, 0, 0, 0, 0, rq);
  endtask
  task automatic fill(logic [31:0] r, int f, logic [31:0] d, string rq);
    cyc(0, 0, 0, 1, 0, r, f, d, 0, rq);
  endtask
  task automatic store(logic [31:0] r, int f, logic [31:0] d, string rq);
    cyc(0, 0, 0, 1, 1, r, f, d, 0, rq);
  endtask
  task automatic idle(string rq);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, rq);
  endtask

  // Monitor: compares each answer one cycle after its request
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      n_cmp++;
      if (lk_valid_o !== e.vld || lk_hit_o !== (e.vld & e.hit) ||
          lk_data_o !== e.data) begin
        n_bad++;
        $display("FAIL %s: got vld=%0b hit=%0b data=%h, expected vld=%0b hit=%0b data=%h",
                 e.rq, lk_valid_o, lk_hit_o, lk_data_o, e.vld, e.hit, e.data);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      report();
    end
  end

  localparam logic [31:0] OA = 32'h1000, OB = 32'h2000, OC = 32'h3000,
                          OD = 32'h4000, OE = 32'h5000, OF = 32'h6000,
                          OG = 32'h7000;

  initial begin
    for (int w = 0; w < WAYS; w++) begin m_val[w] = '0; m_tag[w] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R11 reset state at the ports
    n_cmp++;
    if (lk_valid_o !== 0 || lk_hit_o !== 0 || lk_data_o !== 0) begin
      n_bad++;
      $display("FAIL R11: got vld=%0b hit=%0b data=%h, expected 0 0 0",
               lk_valid_o, lk_hit_o, lk_data_o);
    end
    look(OA, 0, "R11 empty after reset");
    idle("R1 no answer without request");
    // R5 first allocation, R2 hit data, R4 partial line
    fill(OA, 1, 32'hA1A1_0001, "R5 fill miss");
    look(OA, 1, "R2 hit after fill");
    look(OA, 0, "R4 unwritten field misses");
    // R6 fill into resident line
    fill(OA, 0, 32'hA0A0_0000, "R6 fill hit");
    look(OA, 0, "R6 new field hits");
    look(OA, 1, "R6 old field kept");
    look(OA, 3, "R4 other field still invalid");
    // R5 round robin eviction order
    fill(OB, 2, 32'hB2B2_0002, "R5 alloc line1");
    fill(OC, 3, 32'hC3C3_0003, "R5 alloc evicts line0");
    look(OA, 1, "R5 first object evicted");
    look(OB, 2, "R5 second object kept");
    look(OC, 3, "R5 new object present");
    fill(OD, 0, 32'hD0D0_0000, "R5 alloc evicts line1");
    look(OB, 2, "R5 second object evicted");
    // R3 repeated fill of resident reference stays in its line
    fill(OC, 1, 32'hC1C1_0001, "R3 same ref other field");
    look(OD, 0, "R3 neighbour line untouched");
    look(OC, 1, "R3 field added in place");
    // R7 write-through store on resident object
    store(OC, 3, 32'h5555_AAAA, "R7 store hit");
    look(OC, 3, "R7 stored word returned");
    store(OD, 2, 32'h0D0D_2222, "R7 store marks field valid");
    look(OD, 2, "R7 stored field hits");
    // R8 store miss: no allocation, pointer unmoved (next alloc hits line0)
    store(OE, 0, 32'hEEEE_EEEE, "R8 store miss");
    look(OE, 0, "R8 no line allocated");
    look(OC, 3, "R8 nothing evicted");
    fill(OF, 2, 32'hF2F2_0002, "R8 pointer unchanged so line0 replaced");
    look(OC, 3, "R8 line0 object replaced");
    look(OD, 0, "R8 line1 object kept");
    // R10 same-cycle lookup and write
    cyc(1, OF, 0, 1, 0, OF, 0, 32'hF0F0_0000, 0, "R10 lookup sees old state");
    look(OF, 0, "R10 write visible next cycle");
    cyc(1, OF, 2, 1, 1, OF, 2, 32'h1234_5678, 0, "R10 store same cycle old data");
    look(OF, 2, "R10 store data visible");
    // R9 flush with a concurrent write
    cyc(1, OD, 0, 1, 0, OG, 1, 32'h7777_0001, 1, "R9 lookup during flush old state");
    look(OD, 0, "R9 flushed line misses");
    look(OF, 2, "R9 flushed line misses");
    look(OG, 1, "R9 write dropped under flush");
    fill(OG, 1, 32'h7777_0002, "R9 fill after flush");
    look(OG, 1, "R9 refill hits");
    idle("R1 idle"); idle("R1 idle"); idle("R1 idle");
    done = 1;
    report();
  end

endmodule